// File: doc/BRIEF.md
# Lockable System Control Register File

This block is the small control register file of a secure microcontroller subsystem. It sits behind an APB-style slave port inside a 4 KB address window. Through it, software can read why the last reset happened and set the reset mask. It can also keep a retention word, program the boot vectors of two cores, hold cores in a wait state and release them, set and clear secure-debug enables, request a system reset, and update power-domain sense words. It also exposes fixed identification words.

Several registers guard themselves against later writes. The core-0 boot vector locks itself once its lock bit is written as 1. The power control register accepts writes only while its unlock bit reads 1. A core is released, with a power-on-and-reset pulse, only when its wait bit goes from 1 to 0. Every transfer completes with zero wait states. Rejected or illegal accesses raise `pslverr` in the access phase.

Top module: `sysctl_regs`

## Requirements
- R1: After reset, the registers hold these values:
  - reset cause (0x100) = 1;
  - reset mask (0x104), retention (0x10C), debug status (0x000) and all sense words except the system one = 0;
  - system sense (0x200) = 0x7F;
  - power control (0x120) = 0x1;
  - boot vector 0 (0x110), boot vector 1 (0x114) and core wait (0x118) = their reset parameters.
- R2: These offsets read back the last value written: reset cause 0x100, reset mask 0x104, retention 0x10C, boot vector 1 at 0x114, and the sense words at 0x200, 0x204 and 0x20C through 0x218.
- R3: Boot vector 0 at 0x110 has a lock in bit 0. While that bit reads 1, a write leaves the register unchanged and raises `pslverr`.
- R4: `boot_vec0` equals the 0x110 register with bits 6:0 forced to 0. `boot_vec1` equals the 0x114 register.
- R5: Bit i of the core wait register at 0x118 controls core i; only the low NCORES bits are stored. A write that changes bit i from 1 to 0 makes `core_release[i]` high for exactly one cycle, on the edge after the write. Any other write produces no pulse.
- R6: Writing 0x004 ORs the data into the debug status. Writing 0x008 clears each status bit written as 1. The status at 0x000 is read-only, and a write to it raises `pslverr` and changes nothing.
- R7: Writing 0x108 with bit 9 set makes `sys_reset_req` high for one cycle, on the edge after the write. Writes with bit 9 clear have no effect.
- R8: Power control at 0x120 holds bit 0 (unlock) and bit 1 (filter). A write takes effect only while bit 0 reads 1. Otherwise the write is dropped and raises `pslverr`.
- R9: The twelve words at 0xFD0 through 0xFFC read, in address order: 0x04, 0x00, 0x00, 0x00, 0x54, 0xB8, 0x0B, 0x00, 0x0D, 0xF0, 0x05, 0xB1. Writing any of them raises `pslverr`.
- R10: Reading a write-only offset (0x004, 0x008, 0x108) returns 0 without error. Any access to an unmapped offset reads 0 and raises `pslverr`.
- R11: `pready` is always 1, and `pslverr` is high only when `psel` and `penable` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write |
| paddr | input | 12 | Byte address within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Transfer complete (always 1) |
| pslverr | output | 1 | Access error |
| core_release | output | NCORES | Per-core power-on-and-reset pulse |
| sys_reset_req | output | 1 | System reset request pulse |
| boot_vec0 | output | 32 | Core-0 boot vector |
| boot_vec1 | output | 32 | Core-1 boot vector |

## Verification
A corrupt lock or unlock bit shows up on the next write to that register. The write would raise or omit `pslverr` in the same access phase, and the readback would differ in the next transfer. A wrong wait bit is visible as a missing or extra `core_release` pulse one edge after the clearing write. Stale debug status or sense state is visible on the very next read of that offset.

// File: rtl/sysctl_regs.sv
module sysctl_regs #(
  parameter int          NCORES   = 2,
  parameter logic [31:0] VEC0_RST = 32'h1000_0000,
  parameter logic [31:0] VEC1_RST = 32'h1000_0000,
  parameter logic [NCORES-1:0] WAIT_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [11:0]       paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  output logic [NCORES-1:0] core_release,
  output logic              sys_reset_req,
  output logic [31:0]       boot_vec0,
  output logic [31:0]       boot_vec1
);
  localparam logic [9:0] W_DBG   = 10'h000, W_DSET = 10'h001, W_DCLR = 10'h002;
  localparam logic [9:0] W_CAUSE = 10'h040, W_MASK = 10'h041, W_SWRST = 10'h042;
  localparam logic [9:0] W_RET   = 10'h043, W_VEC0 = 10'h044, W_VEC1  = 10'h045;
  localparam logic [9:0] W_WAIT  = 10'h046, W_PWR  = 10'h048;
  localparam logic [9:0] W_SENSE = 10'h080, W_ID   = 10'h3F4;
  localparam int NSENSE = 6;

  logic [31:0] dbg_q, cause_q, mask_q, ret_q, vec0_q, vec1_q;
  logic [NCORES-1:0] wait_q;
  logic [1:0]  pwr_q;
  logic [31:0] sense_q [NSENSE];

  logic [9:0] widx;
  logic acc, wr, rd, mapped, ro_hit, is_sense, is_id;
  logic [2:0] sidx;
  logic [31:0] rdata;

  assign widx  = paddr[11:2];
  assign acc   = psel & penable;
  assign wr    = acc & pwrite;
  assign rd    = acc & ~pwrite;
  assign pready = 1'b1;
  assign is_id = widx >= W_ID;
  assign boot_vec0 = {vec0_q[31:7], 7'b0};
  assign boot_vec1 = vec1_q;

  function automatic logic [7:0] id_byte(input logic [3:0] i);
    case (i)
      4'd0: id_byte = 8'h04;  4'd4: id_byte = 8'h54;  4'd5: id_byte = 8'hB8;
      4'd6: id_byte = 8'h0B;  4'd8: id_byte = 8'h0D;  4'd9: id_byte = 8'hF0;
      4'd10: id_byte = 8'h05; 4'd11: id_byte = 8'hB1;
      default: id_byte = 8'h00;
    endcase
  endfunction

  always_comb begin
    is_sense = 1'b0;
    sidx = '0;
    case (widx)
      W_SENSE:          begin is_sense = 1'b1; sidx = 3'd0; end
      W_SENSE + 10'd1:  begin is_sense = 1'b1; sidx = 3'd1; end
      W_SENSE + 10'd3:  begin is_sense = 1'b1; sidx = 3'd2; end
      W_SENSE + 10'd4:  begin is_sense = 1'b1; sidx = 3'd3; end
      W_SENSE + 10'd5:  begin is_sense = 1'b1; sidx = 3'd4; end
      W_SENSE + 10'd6:  begin is_sense = 1'b1; sidx = 3'd5; end
      default: ;
    endcase
  end

  always_comb begin
    rdata  = '0;
    mapped = 1'b1;
    ro_hit = 1'b0;
    case (widx)
      W_DBG:   begin rdata = dbg_q; ro_hit = 1'b1; end
      W_DSET, W_DCLR, W_SWRST: rdata = '0;
      W_CAUSE: rdata = cause_q;
      W_MASK:  rdata = mask_q;
      W_RET:   rdata = ret_q;
      W_VEC0:  rdata = vec0_q;
      W_VEC1:  rdata = vec1_q;
      W_WAIT:  rdata = 32'(wait_q);
      W_PWR:   rdata = {30'b0, pwr_q};
      default:
        if (is_sense) rdata = sense_q[sidx];
        else if (is_id) begin
          rdata = {24'b0, id_byte(4'(widx - W_ID))};
          ro_hit = 1'b1;
        end else mapped = 1'b0;
    endcase
  end

  assign prdata  = rd ? rdata : '0;
  assign pslverr = acc & (~mapped | (pwrite & (ro_hit |
                   (widx == W_VEC0 & vec0_q[0]) | (widx == W_PWR & ~pwr_q[0]))));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbg_q <= '0; cause_q <= 32'd1; mask_q <= '0; ret_q <= '0;
      vec0_q <= VEC0_RST; vec1_q <= VEC1_RST; wait_q <= WAIT_RST;
      pwr_q <= 2'b01; core_release <= '0; sys_reset_req <= 1'b0;
      for (int i = 0; i < NSENSE; i++) sense_q[i] <= (i == 0) ? 32'h7F : 32'h0;
    end else begin
      core_release  <= '0;
      sys_reset_req <= 1'b0;
      if (wr) begin
        case (widx)
          W_DSET:  dbg_q <= dbg_q | pwdata;
          W_DCLR:  dbg_q <= dbg_q & ~pwdata;
          W_CAUSE: cause_q <= pwdata;
          W_MASK:  mask_q <= pwdata;
          W_SWRST: sys_reset_req <= pwdata[9];
          W_RET:   ret_q <= pwdata;
          W_VEC0:  if (!vec0_q[0]) vec0_q <= pwdata;
          W_VEC1:  vec1_q <= pwdata;
          W_WAIT: begin
            core_release <= wait_q & ~pwdata[NCORES-1:0];
            wait_q <= pwdata[NCORES-1:0];
          end
          W_PWR:   if (pwr_q[0]) pwr_q <= pwdata[1:0];
          default: if (is_sense) sense_q[sidx] <= pwdata;
        endcase
      end
    end
  end

  p_vec0_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vec0_q[0] |=> vec0_q[0] && $stable(vec0_q));
  p_release_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|core_release) |-> $past(wr && widx == W_WAIT));
  p_sysrst_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |=> !sys_reset_req);
  p_pwr_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_q[0] |=> $stable(pwr_q));
  p_err_phase_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pslverr |-> psel && penable);
  p_vec_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    boot_vec0[6:0] == 7'b0);
endmodule

// File: tb/sysctl_regs_tb_top.sv
module sysctl_regs_tb_top;
  localparam logic [31:0] V0 = 32'h1000_0080, V1 = 32'h2000_0000;
  logic clk = 0, rst_n = 0, psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata, boot_vec0, boot_vec1;
  logic pready, pslverr, sys_reset_req;
  logic [1:0] core_release;
  logic [1:0] rel_seen;
  logic rst_seen, err_seen;
  int total = 0, bad = 0;

  sysctl_regs #(.NCORES(2), .VEC0_RST(V0), .VEC1_RST(V1), .WAIT_RST(2'b11)) dut_i (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .core_release(core_release), .sys_reset_req(sys_reset_req),
    .boot_vec0(boot_vec0), .boot_vec1(boot_vec1));

  always #2 clk = ~clk;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1; #1 err_seen = pslverr;
    @(negedge clk); rel_seen = core_release; rst_seen = sys_reset_req;
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1; #1 d = prdata; err_seen = pslverr;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(12'h100, d); chk("R1 cause", d, 1);
    rd(12'h104, d); chk("R1 mask", d, 0);
    rd(12'h200, d); chk("R1 sys sense", d, 32'h7F);
    rd(12'h218, d); chk("R1 sram3 sense", d, 0);
    rd(12'h118, d); chk("R1 wait", d, 3);
    rd(12'h120, d); chk("R1 pwr", d, 1);
    rd(12'h110, d); chk("R1 vec0", d, V0);
    chk("R4 boot_vec1", boot_vec1, V1);
    chk("R11 pready", {31'b0, pready}, 1);
  endtask

  task automatic t_rw();
    logic [31:0] d;
    wr(12'h100, 32'hA5A5_0003); rd(12'h100, d); chk("R2 cause", d, 32'hA5A5_0003);
    wr(12'h104, 32'h0000_FFFF); rd(12'h104, d); chk("R2 mask", d, 32'h0000_FFFF);
    wr(12'h10C, 32'hDEAD_BEEF); rd(12'h10C, d); chk("R2 retention", d, 32'hDEAD_BEEF);
    wr(12'h114, 32'h3000_0401); rd(12'h114, d); chk("R2 vec1", d, 32'h3000_0401);
    chk("R4 boot_vec1", boot_vec1, 32'h3000_0401);
    wr(12'h210, 32'h1234); rd(12'h210, d); chk("R2 sense", d, 32'h1234);
  endtask

  task automatic t_vec0();
    logic [31:0] d;
    chk("R4 boot_vec0 reset", boot_vec0, V0);
    wr(12'h110, 32'h1234_56FE); chk("R3 unlocked err", {31'b0, err_seen}, 0);
    chk("R4 boot_vec0 mask", boot_vec0, 32'h1234_5680);
    wr(12'h110, 32'h2000_0181); rd(12'h110, d); chk("R3 lock set", d, 32'h2000_0181);
    wr(12'h110, 32'hFFFF_FF00); chk("R3 locked err", {31'b0, err_seen}, 1);
    rd(12'h110, d); chk("R3 locked value", d, 32'h2000_0181);
    chk("R4 boot_vec0", boot_vec0, 32'h2000_0180);
  endtask

  task automatic t_release();
    wr(12'h118, 32'h2); chk("R5 release core0", {30'b0, rel_seen}, 1);
    @(negedge clk); chk("R5 pulse width", {30'b0, core_release}, 0);
    wr(12'h118, 32'h0); chk("R5 release core1", {30'b0, rel_seen}, 2);
    wr(12'h118, 32'h3); chk("R5 set no pulse", {30'b0, rel_seen}, 0);
    wr(12'h118, 32'h3); chk("R5 hold no pulse", {30'b0, rel_seen}, 0);
    wr(12'h118, 32'hFFFF_FFFC); chk("R5 both", {30'b0, rel_seen}, 3);
  endtask

  task automatic t_debug();
    logic [31:0] d;
    wr(12'h004, 32'h5);  rd(12'h000, d); chk("R6 set", d, 32'h5);
    wr(12'h004, 32'h30); rd(12'h000, d); chk("R6 set or", d, 32'h35);
    wr(12'h008, 32'h14); rd(12'h000, d); chk("R6 clear", d, 32'h21);
    wr(12'h000, 32'hFF); chk("R6 ro err", {31'b0, err_seen}, 1);
    rd(12'h000, d); chk("R6 ro unchanged", d, 32'h21);
  endtask

  task automatic t_swrst();
    logic [31:0] d;
    wr(12'h108, 32'hFFFF_FDFF); chk("R7 no req", {31'b0, rst_seen}, 0);
    wr(12'h108, 32'h200); chk("R7 req", {31'b0, rst_seen}, 1);
    @(negedge clk); chk("R7 pulse width", {31'b0, sys_reset_req}, 0);
    rd(12'h108, d); chk("R10 wo read", d, 0);
    chk("R10 wo no err", {31'b0, err_seen}, 0);
  endtask

  task automatic t_pwr();
    logic [31:0] d;
    wr(12'h120, 32'h3); rd(12'h120, d); chk("R8 unlocked write", d, 3);
    wr(12'h120, 32'h2); chk("R8 lock err", {31'b0, err_seen}, 0);
    rd(12'h120, d); chk("R8 locked", d, 2);
    wr(12'h120, 32'h3); chk("R8 dropped err", {31'b0, err_seen}, 1);
    rd(12'h120, d); chk("R8 dropped", d, 2);
  endtask

  task automatic t_id();
    logic [31:0] d;
    logic [7:0] exp [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h54, 8'hB8,
                             8'h0B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int i = 0; i < 12; i++) begin
      rd(12'hFD0 + 12'(4 * i), d); chk("R9 id", d, {24'b0, exp[i]});
    end
    wr(12'hFE0, 32'h1); chk("R9 write err", {31'b0, err_seen}, 1);
    rd(12'hFE0, d); chk("R9 unchanged", d, 32'h54);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    rd(12'h300, d); chk("R10 unmapped data", d, 0);
    chk("R10 unmapped err", {31'b0, err_seen}, 1);
    wr(12'h208, 32'h1); chk("R10 unmapped wr err", {31'b0, err_seen}, 1);
    @(negedge clk); psel = 1; penable = 0; paddr = 12'h300; #1;
    chk("R11 no err in setup", {31'b0, pslverr}, 0);
    @(negedge clk); psel = 0;
  endtask

  initial begin
    #40000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_rw(); t_vec0(); t_release(); t_debug();
    t_swrst(); t_pwr(); t_id(); t_unmapped();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule